// File: doc/BRIEF.md
# Multiplexed Shared-Bus Resolver

This block stands in for an on-chip three-state bus. Each of `N_DRV` drivers presents a `WIDTH`-bit word and an output-enable bit. The drivers share no physical three-state buffers. Instead, the block counts the active enables and picks one of three outcomes:

- With a single enable high, the bus carries that driver's word.
- With no enable high, the bus reads as all ones.
- With two or more enables high, the bus is forced to all zeros.

The result never contains a high-impedance or undefined value. Two flags report the fallback cases: `clash` means two or more drivers are fighting for the bus, and `vacant` means no driver is enabled.

The parameter `REG_OUT` chooses how the result leaves the block. With `REG_OUT = 0` the bus and the flags are purely combinational. With `REG_OUT = 1` they pass through an output register stage. That stage has an asynchronous active-low reset, and the reset is released synchronously inside the block. Users who need timing closure across a wide driver set use the registered form. Users who need zero latency use the combinational form.

Top module: `tsbus_emul`

## Requirements
- R1: When exactly one bit of `drv_oe` is high, `bus_q` equals the word of that driver, taken from `drv_data[i*WIDTH +: WIDTH]` for driver i.
- R2: When two or more bits of `drv_oe` are high, every bit of `bus_q` is 0.
- R3: When no bit of `drv_oe` is high, every bit of `bus_q` is 1.
- R4: `clash` is 1 exactly when two or more enables are high, and 0 otherwise.
- R5: `vacant` is 1 exactly when all enables are low, and 0 otherwise.
- R6: With `REG_OUT = 0`, `bus_q`, `clash` and `vacant` follow the inputs within the same cycle, with no clock edge needed.
- R7: With `REG_OUT = 1`, the outputs show the result for the inputs present at the previous rising clock edge. They do not change between edges.
- R8: With `REG_OUT = 1`, driving `rst_n` low immediately forces the outputs to the no-driver state: `bus_q` all ones, `vacant` 1, `clash` 0. They stay there until reset has been released and synchronised.
- R9: While one driver is enabled, the data words of the disabled drivers have no effect on `bus_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register stage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| drv_data | input | N_DRV*WIDTH | Packed driver words; driver i occupies bits [i*WIDTH +: WIDTH] |
| drv_oe | input | N_DRV | Output-enable per driver, bit i for driver i |
| bus_q | output | WIDTH | Resolved bus value |
| clash | output | 1 | Two or more drivers enabled |
| vacant | output | 1 | No driver enabled |

## Verification
The bench runs every enable pattern of a four-driver bus with fresh random words. This catches two classes of error. A design that ORs all enabled words instead of zeroing on contention leaks data onto the bus. A design that treats the count as saturating in the wrong place flags one driver as a clash.

It holds one driver enabled and changes the words of the disabled drivers. An AND-OR mux with a masking mistake would show those bits. The registered variant is probed just before and just after a clock edge, which exposes an off-by-one latency or a stage that is transparent. An asynchronous reset asserted mid-cycle shows whether the output stage falls to the idle value at once or waits for a clock.

// File: rtl/tsbus_pkg.sv
package tsbus_pkg;

  // Outcome of counting the active output enables.
  typedef enum logic [1:0] {
    BUS_FLOAT  = 2'd0,  // no driver enabled
    BUS_SINGLE = 2'd1,  // exactly one driver enabled
    BUS_CLASH  = 2'd2   // two or more drivers enabled
  } bus_case_e;

endpackage

// File: rtl/tsbus_oe_count.sv
module tsbus_oe_count
  import tsbus_pkg::*;
#(
  parameter int N_DRV = 4
) (
  input  logic [N_DRV-1:0] drv_oe,
  output bus_case_e        bus_case
);

  localparam int CW = $clog2(N_DRV + 1);

  logic [CW-1:0] oe_cnt;

  // Population count of the enable vector.
  always_comb begin
    oe_cnt = '0;
    for (int i = 0; i < N_DRV; i++) begin
      oe_cnt = oe_cnt + CW'(drv_oe[i]);
    end
  end

  always_comb begin
    if (oe_cnt == '0) begin
      bus_case = BUS_FLOAT;
    end else if (oe_cnt == CW'(1)) begin
      bus_case = BUS_SINGLE;
    end else begin
      bus_case = BUS_CLASH;
    end
  end

endmodule

// File: rtl/tsbus_andor_mux.sv
module tsbus_andor_mux #(
  parameter int N_DRV = 4,
  parameter int WIDTH = 8
) (
  input  logic [N_DRV*WIDTH-1:0] drv_data,
  input  logic [N_DRV-1:0]       drv_oe,
  output logic [WIDTH-1:0]       mux_word
);

  // Each word is masked by its own enable, then all are ORed.
  // This is only meaningful when at most one enable is set.
  logic [WIDTH-1:0] masked [N_DRV];

  genvar g;
  generate
    for (g = 0; g < N_DRV; g++) begin : g_mask
      assign masked[g] = drv_data[g*WIDTH +: WIDTH] & {WIDTH{drv_oe[g]}};
    end
  endgenerate

  always_comb begin
    mux_word = '0;
    for (int i = 0; i < N_DRV; i++) begin
      mux_word = mux_word | masked[i];
    end
  end

endmodule

// File: rtl/tsbus_resolve.sv
module tsbus_resolve
  import tsbus_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bus_case_e        bus_case,
  input  logic [WIDTH-1:0] mux_word,
  output logic [WIDTH-1:0] bus_nxt,
  output logic             clash_nxt,
  output logic             vacant_nxt
);

  always_comb begin
    bus_nxt    = '1;
    clash_nxt  = 1'b0;
    vacant_nxt = 1'b0;
    unique case (bus_case)
      BUS_FLOAT: begin
        bus_nxt    = '1;
        vacant_nxt = 1'b1;
      end
      BUS_SINGLE: begin
        bus_nxt = mux_word;
      end
      BUS_CLASH: begin
        bus_nxt   = '0;
        clash_nxt = 1'b1;
      end
      default: begin
        bus_nxt    = '1;
        vacant_nxt = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tsbus_out_stage.sv
module tsbus_out_stage #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_nxt,
  input  logic             clash_nxt,
  input  logic             vacant_nxt,
  output logic [WIDTH-1:0] bus_q,
  output logic             clash,
  output logic             vacant
);

  generate
    if (REG_OUT) begin : g_reg
      logic [1:0]       rst_sync;
      logic             rst_int_n;
      logic             stage_en;
      logic [WIDTH-1:0] bus_r;
      logic             clash_r;
      logic             vacant_r;

      // Reset asserts asynchronously and is released through two flops.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_sync <= 2'b00;
        end else begin
          rst_sync <= {rst_sync[0], 1'b1};
        end
      end
      assign rst_int_n = rst_sync[1];

      // The stage loads on every edge once out of reset.
      assign stage_en = 1'b1;

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          bus_r    <= '1;
          clash_r  <= 1'b0;
          vacant_r <= 1'b1;
        end else if (stage_en) begin
          bus_r    <= bus_nxt;
          clash_r  <= clash_nxt;
          vacant_r <= vacant_nxt;
        end
      end

      assign bus_q  = bus_r;
      assign clash  = clash_r;
      assign vacant = vacant_r;
    end else begin : g_comb
      assign bus_q  = bus_nxt;
      assign clash  = clash_nxt;
      assign vacant = vacant_nxt;
    end
  endgenerate

endmodule

// File: rtl/tsbus_emul.sv
module tsbus_emul
  import tsbus_pkg::*;
#(
  parameter int N_DRV   = 4,
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DRV*WIDTH-1:0] drv_data,
  input  logic [N_DRV-1:0]       drv_oe,
  output logic [WIDTH-1:0]       bus_q,
  output logic                   clash,
  output logic                   vacant
);

  bus_case_e        bus_case;
  logic [WIDTH-1:0] mux_word;
  logic [WIDTH-1:0] bus_nxt;
  logic             clash_nxt;
  logic             vacant_nxt;

  tsbus_oe_count #(.N_DRV(N_DRV)) u_count (
    .drv_oe   (drv_oe),
    .bus_case (bus_case)
  );

  tsbus_andor_mux #(.N_DRV(N_DRV), .WIDTH(WIDTH)) u_mux (
    .drv_data (drv_data),
    .drv_oe   (drv_oe),
    .mux_word (mux_word)
  );

  tsbus_resolve #(.WIDTH(WIDTH)) u_resolve (
    .bus_case   (bus_case),
    .mux_word   (mux_word),
    .bus_nxt    (bus_nxt),
    .clash_nxt  (clash_nxt),
    .vacant_nxt (vacant_nxt)
  );

  tsbus_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_nxt    (bus_nxt),
    .clash_nxt  (clash_nxt),
    .vacant_nxt (vacant_nxt),
    .bus_q      (bus_q),
    .clash      (clash),
    .vacant     (vacant)
  );

endmodule

// File: rtl/tsbus_emul_chk.sv
module tsbus_emul_chk #(
  parameter int N_DRV   = 4,
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DRV-1:0] drv_oe,
  input logic [WIDTH-1:0] bus_q,
  input logic             clash,
  input logic             vacant
);

  // Cycles since reset release, saturating once the synchronised
  // reset has let the output stage load real data.
  logic [1:0] rel_cnt;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= 2'd0;
    end else if (rel_cnt != 2'd3) begin
      rel_cnt <= rel_cnt + 2'd1;
    end
  end
  assign settled = (rel_cnt == 2'd3);

  // R2: a clash always drives the bus to zero
  a_r2_clash_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (bus_q == '0));

  // R3: an unused bus always reads all ones
  a_r3_vacant_ones: assert property (@(posedge clk) disable iff (!rst_n)
    vacant |-> (bus_q == '1));

  // R4, R5: the two fallback flags never appear together
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(clash && vacant));

  generate
    if (REG_OUT) begin : g_reg_props
      // R7: the flags reflect the enables seen at the previous edge
      a_r7_clash_latency: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        clash == ($countones($past(drv_oe)) > 1));
      a_r7_vacant_latency: assert property (@(posedge clk)
        disable iff (!rst_n || !settled)
        vacant == ($past(drv_oe) == '0));
    end else begin : g_comb_props
      // R4: clash tracks the enable count in the same cycle
      a_r4_clash_count: assert property (@(posedge clk) disable iff (!rst_n)
        clash == ($countones(drv_oe) > 1));
      // R5: vacant tracks an all-low enable vector in the same cycle
      a_r5_vacant_none: assert property (@(posedge clk) disable iff (!rst_n)
        vacant == (drv_oe == '0));
    end
  endgenerate

endmodule

bind tsbus_emul tsbus_emul_chk #(
  .N_DRV   (N_DRV),
  .WIDTH   (WIDTH),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .drv_oe (drv_oe),
  .bus_q  (bus_q),
  .clash  (clash),
  .vacant (vacant)
);

// File: tb/tsbus_emul_tb_top.sv
`timescale 1ns/1ps
module tsbus_emul_tb_top;

  localparam int N = 4;
  localparam int W = 8;

  logic           clk;
  logic           rst_n;
  logic [N*W-1:0] drv_data;
  logic [N-1:0]   drv_oe;
  logic [W-1:0]   bus_c, bus_r;
  logic           clash_c, clash_r, vacant_c, vacant_r;

  int n_checks = 0;
  int n_errors = 0;

  // Expected registered outputs (value captured at the last edge)
  logic [W-1:0] held_bus;
  logic         held_clash, held_vacant;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  tsbus_emul #(.N_DRV(N), .WIDTH(W), .REG_OUT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .drv_data(drv_data), .drv_oe(drv_oe),
    .bus_q(bus_c), .clash(clash_c), .vacant(vacant_c)
  );

  tsbus_emul #(.N_DRV(N), .WIDTH(W), .REG_OUT(1'b1)) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .drv_data(drv_data), .drv_oe(drv_oe),
    .bus_q(bus_r), .clash(clash_r), .vacant(vacant_r)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [W-1:0] exp_bus(input logic [N-1:0] oe,
                                           input logic [N*W-1:0] d);
    int c = ones(oe);
    if (c == 0) return '1;
    if (c > 1) return '0;
    for (int i = 0; i < N; i++) if (oe[i]) return d[i*W +: W];
    return '1;
  endfunction

  function automatic string bus_req(input logic [N-1:0] oe);
    int c = ones(oe);
    if (c == 0) return "R3";
    if (c == 1) return "R1";
    return "R2";
  endfunction

  task automatic rand_data();
    for (int i = 0; i < N; i++) drv_data[i*W +: W] = W'($urandom);
  endtask

  task automatic check_comb();
    check(bus_req(drv_oe), "comb bus", 64'(bus_c), 64'(exp_bus(drv_oe, drv_data)));
    check("R4", "comb clash", 64'(clash_c), 64'(ones(drv_oe) > 1));
    check("R5", "comb vacant", 64'(vacant_c), 64'(ones(drv_oe) == 0));
  endtask

  task automatic check_reg_idle(input string req);
    check(req, "reg bus idle", 64'(bus_r), 64'({W{1'b1}}));
    check(req, "reg vacant idle", 64'(vacant_r), 64'd1);
    check(req, "reg clash idle", 64'(clash_r), 64'd0);
  endtask

  // R8: outputs during reset
  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check_reg_idle("R8");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reg_idle("R8");
  endtask

  // R1 R2 R3 R4 R5: every enable pattern, random words
  task automatic t_exhaustive(input int rounds);
    for (int r = 0; r < rounds; r++) begin
      for (int p = 0; p < (1 << N); p++) begin
        @(negedge clk);
        drv_oe = N'(p);
        rand_data();
        #1;
        check_comb();
      end
    end
  endtask

  // R6: combinational result changes with no clock edge in between
  task automatic t_comb_noclock();
    @(negedge clk);
    drv_oe = 4'b0010;
    rand_data();
    #0.5;
    check("R6", "bus first", 64'(bus_c), 64'(drv_data[1*W +: W]));
    drv_oe = 4'b0110;
    #0.5;
    check("R6", "bus after clash", 64'(bus_c), 64'd0);
    drv_oe = 4'b0000;
    #0.5;
    check("R6", "bus after release", 64'(bus_c), 64'(8'hFF));
  endtask

  // R9: disabled drivers' words cannot reach the bus
  task automatic t_ignored();
    logic [W-1:0] keep;
    @(negedge clk);
    drv_oe = 4'b0100;
    rand_data();
    keep = drv_data[2*W +: W];
    for (int k = 0; k < 8; k++) begin
      #0.3;
      for (int i = 0; i < N; i++)
        if (i != 2) drv_data[i*W +: W] = W'($urandom);
      #0.1;
      check("R9", "bus with others changing", 64'(bus_c), 64'(keep));
    end
  endtask

  // R7: registered stage latency and stability between edges
  task automatic t_registered();
    @(negedge clk);
    held_bus    = exp_bus(drv_oe, drv_data);
    held_clash  = ones(drv_oe) > 1;
    held_vacant = ones(drv_oe) == 0;
    for (int p = 0; p < (1 << N); p++) begin
      @(negedge clk);
      drv_oe = N'(p);
      rand_data();
      #1;
      check("R7", "reg bus before edge", 64'(bus_r), 64'(held_bus));
      check("R7", "reg clash before edge", 64'(clash_r), 64'(held_clash));
      held_bus    = exp_bus(drv_oe, drv_data);
      held_clash  = ones(drv_oe) > 1;
      held_vacant = ones(drv_oe) == 0;
      @(posedge clk);
      #1;
      check("R7", "reg bus after edge", 64'(bus_r), 64'(held_bus));
      check("R7", "reg clash after edge", 64'(clash_r), 64'(held_clash));
      check("R7", "reg vacant after edge", 64'(vacant_r), 64'(held_vacant));
    end
  endtask

  // R8: asynchronous reset in mid-cycle
  task automatic t_async_reset();
    @(negedge clk);
    drv_oe = 4'b0001;
    rand_data();
    @(posedge clk);
    #1;
    check("R7", "reg bus loaded", 64'(bus_r), 64'(drv_data[W-1:0]));
    rst_n = 1'b0;
    #0.5;
    check_reg_idle("R8");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_reg_idle("R8");
    repeat (4) @(negedge clk);
    #1;
    check("R7", "reg bus after reset release", 64'(bus_r), 64'(drv_data[W-1:0]));
  endtask

  initial begin
    rst_n    = 1'b0;
    drv_oe   = '0;
    drv_data = '0;
    t_reset();
    t_exhaustive(3);
    t_comb_noclock();
    t_ignored();
    t_registered();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule